// File: doc/BRIEF.md
# 8b/10b Receive Status Classifier

This block sits after a table-level 10b-to-8b decoder in a serial receiver and runs once per received character. For each character it takes the decoder's result and the disparity columns that character's encoding fits. It combines these with two pieces of state that it keeps itself: the tracked running disparity and the identity of the previous special character. From all of this it produces one 10-bit status word: a violation flag, a special flag and an 8-bit code.

Good characters pass through unchanged. Unassigned codes, comma characters of the wrong polarity, codes that arrive with the wrong running disparity and two marked two-character sequences are replaced by reserved control codes, always with the violation flag set. A reserved code written Cx.y has the 8-bit value `{y[2:0], x[4:0]}`. The running disparity is re-synchronised after every character, so one error does not turn into a burst of errors.

Top module: `rxs_status_classifier`

## Requirements
- R1: After reset, `out_valid` is 0, `out_rd` is 0 (0 means negative running disparity) and no previous special character is remembered.
- R2: A legal data character (`in_ctrl`=0) whose fit bit `in_fit[rd]` is set for the current disparity gives viol=0, spec=0 and code=`in_byte`. Bit 0 of `in_fit` means the character fits a negative start; bit 1 means it fits a positive start.
- R3: A legal special character with an index from 0 to 11 whose fit bit for the current disparity is set gives viol=0, spec=1 and code=index. Special characters arrive as their index in `in_byte`: K28.1 is 1, K28.5 is 5 and K28.7 is 7.
- R4: A good K28.7 that comes directly after a good K28.1 gives viol=1, spec=1, code 0x27 (C7.1). A good K28.7 that comes directly after a good K28.5 gives viol=1, spec=1, code 0x47 (C7.2).
- R5: A character is unassigned when `in_legal`=0, when `in_fit`=00, or when it is special with an index above 11. An unassigned character gives viol=1, spec=1, code 0xE0 (C0.7).
- R6: A K28.5 that fits only a negative start (`in_fit`=01), received while the disparity is positive, gives viol=1, spec=1, code 0xE1 (C1.7). A K28.5 that fits only a positive start (`in_fit`=10), received while the disparity is negative, gives code 0xE2 (C2.7).
- R7: Any other assigned character whose fit bit for the current disparity is clear gives viol=1, spec=1, code 0xE4 (C4.7).
- R8: After every accepted character, errored or not, the tracked disparity `out_rd` equals that character's `in_rd_end`.
- R9: The previous-special memory takes the index of a character only when that character was reported as a good special (R3). Any other character clears it.
- R10: When several conditions hold, the first of these wins: unassigned, comma polarity error, disparity error, sequence code, pass-through.
- R11: `out_valid` equals `in_valid` one cycle later. A cycle with `in_valid`=0 changes neither the disparity nor the previous-special memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decoded character is present |
| in_ctrl | input | 1 | Decoder marks the character as special |
| in_byte | input | 8 | Data value, or special index when `in_ctrl`=1 |
| in_legal | input | 1 | The 10-bit code exists in the code table |
| in_fit | input | 2 | Disparity columns the code fits (bit0 negative, bit1 positive) |
| in_rd_end | input | 1 | Running disparity implied after this character (1 = positive) |
| out_valid | output | 1 | Status word is present |
| out_viol | output | 1 | Violation flag |
| out_spec | output | 1 | Special-character flag |
| out_code | output | 8 | Status code |
| out_rd | output | 1 | Tracked running disparity |

## Verification
The bench sends a continuous stream that sweeps every data byte and the special indices 0 to 15. Each value is tried under all four fit patterns and both legality values, with the ending disparity alternated so that both starting disparities occur. Comparing each output against an arithmetic model separates pass-through from the disparity error and the unassigned code, and it exposes the priority between them. Directed pairs cover the rest: K28.1 or K28.5 followed by K28.7, K28.7 after data, after another K28.7, after an errored comma, and after an idle gap. These separate the sequence codes from plain pass-through and show that the previous-special memory is cleared or kept as specified. The two comma polarities, each against both disparities, separate C1.7 and C2.7 from pass-through.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

   typedef enum logic [2:0] {
      CLS_PASS_DATA = 3'd0,
      CLS_PASS_SPEC = 3'd1,
      CLS_UNASSIGN  = 3'd2,
      CLS_COMMA_NEG = 3'd3,
      CLS_COMMA_POS = 3'd4,
      CLS_DISP_ERR  = 3'd5,
      CLS_SEQ_A     = 3'd6,
      CLS_SEQ_B     = 3'd7
   } rxs_class_e;

   // Reserved control code Cx.y packed as {y, x}
   function automatic logic [7:0] ccode(input int unsigned x, input int unsigned y);
      logic [4:0] xv;
      logic [2:0] yv;
      xv = x[4:0];
      yv = y[2:0];
      return {yv, xv};
   endfunction

   localparam logic [7:0] CODE_UNASSIGN  = ccode(0, 7);
   localparam logic [7:0] CODE_COMMA_NEG = ccode(1, 7);
   localparam logic [7:0] CODE_COMMA_POS = ccode(2, 7);
   localparam logic [7:0] CODE_DISP_ERR  = ccode(4, 7);
   localparam logic [7:0] CODE_SEQ_A     = ccode(7, 1);
   localparam logic [7:0] CODE_SEQ_B     = ccode(7, 2);

endpackage

// File: rtl/rxs_rd_track.sv
module rxs_rd_track #(
   parameter logic RESET_RD = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic chr_en,
   input  logic rd_next,
   output logic rd_cur
);

   always_ff @(posedge clk) begin
      if (!rst_n)      rd_cur <= RESET_RD;
      else if (chr_en) rd_cur <= rd_next;
   end

   p_rd_resync_r8: assert property (@(posedge clk) disable iff (!rst_n)
      chr_en |=> rd_cur == $past(rd_next));
   p_rd_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !chr_en |=> $stable(rd_cur));

endmodule

// File: rtl/rxs_seq_track.sv
module rxs_seq_track #(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chr_en,
   input  logic             good_spec,
   input  logic [IDX_W-1:0] idx_in,
   output logic             prev_vld,
   output logic [IDX_W-1:0] prev_idx
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_vld <= 1'b0;
         prev_idx <= '0;
      end else if (chr_en) begin
         prev_vld <= good_spec;
         prev_idx <= good_spec ? idx_in : '0;
      end
   end

   p_prev_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      chr_en && !good_spec |=> !prev_vld);
   p_prev_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      chr_en && good_spec |=> prev_vld && prev_idx == $past(idx_in));
   p_prev_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !chr_en |=> $stable(prev_vld) && $stable(prev_idx));

endmodule

// File: rtl/rxs_classify.sv
module rxs_classify
   import rxs_pkg::*;
#(
   parameter int CODE_W    = 8,
   parameter int N_SPECIAL = 12,
   parameter int IDX_W     = 4,
   parameter int COMMA_IDX = 5,
   parameter int SEQ_A_IDX = 1,
   parameter int SEQ_B_IDX = 5,
   parameter int TRIG_IDX  = 7
) (
   input  logic              ctrl,
   input  logic [CODE_W-1:0] byte_in,
   input  logic              legal,
   input  logic [1:0]        fit,
   input  logic              rd_cur,
   input  logic              prev_vld,
   input  logic [IDX_W-1:0]  prev_idx,
   output rxs_class_e        cls,
   output logic              viol,
   output logic              spec,
   output logic [CODE_W-1:0] code,
   output logic              good_spec
);

   localparam logic [CODE_W-1:0] LIM   = CODE_W'(N_SPECIAL);
   localparam logic [CODE_W-1:0] COMMA = CODE_W'(COMMA_IDX);
   localparam logic [CODE_W-1:0] TRIG  = CODE_W'(TRIG_IDX);
   localparam logic [IDX_W-1:0]  SEQA  = IDX_W'(SEQ_A_IDX);
   localparam logic [IDX_W-1:0]  SEQB  = IDX_W'(SEQ_B_IDX);

   logic unassigned, fits_now, is_comma, is_trig;

   always_comb begin
      unassigned = !legal || (fit == 2'b00) || (ctrl && (byte_in >= LIM));
      fits_now   = rd_cur ? fit[1] : fit[0];
      is_comma   = ctrl && (byte_in == COMMA);
      is_trig    = ctrl && (byte_in == TRIG);
   end

   // Priority chain: unassigned, comma polarity, disparity, sequence, pass
   always_comb begin
      if (unassigned)                           cls = CLS_UNASSIGN;
      else if (is_comma && !fits_now && fit[0]) cls = CLS_COMMA_NEG;
      else if (is_comma && !fits_now)           cls = CLS_COMMA_POS;
      else if (!fits_now)                       cls = CLS_DISP_ERR;
      else if (is_trig && prev_vld && prev_idx == SEQA) cls = CLS_SEQ_A;
      else if (is_trig && prev_vld && prev_idx == SEQB) cls = CLS_SEQ_B;
      else if (ctrl)                            cls = CLS_PASS_SPEC;
      else                                      cls = CLS_PASS_DATA;
   end

   always_comb begin
      viol = 1'b1;
      spec = 1'b1;
      code = byte_in;
      unique case (cls)
         CLS_PASS_DATA: begin viol = 1'b0; spec = 1'b0; end
         CLS_PASS_SPEC: viol = 1'b0;
         CLS_UNASSIGN:  code = CODE_W'(CODE_UNASSIGN);
         CLS_COMMA_NEG: code = CODE_W'(CODE_COMMA_NEG);
         CLS_COMMA_POS: code = CODE_W'(CODE_COMMA_POS);
         CLS_DISP_ERR:  code = CODE_W'(CODE_DISP_ERR);
         CLS_SEQ_A:     code = CODE_W'(CODE_SEQ_A);
         CLS_SEQ_B:     code = CODE_W'(CODE_SEQ_B);
         default:       code = CODE_W'(CODE_UNASSIGN);
      endcase
      good_spec = (cls == CLS_PASS_SPEC);
   end

   p_pass_clean_r2: assert final (!(cls == CLS_PASS_DATA) || (legal && fits_now && !ctrl && !viol));
   p_reserved_ctrl_r5: assert final (!viol || spec);

endmodule

// File: rtl/rxs_status_classifier.sv
module rxs_status_classifier
   import rxs_pkg::*;
#(
   parameter int   CODE_W    = 8,
   parameter int   N_SPECIAL = 12,
   parameter int   COMMA_IDX = 5,
   parameter int   SEQ_A_IDX = 1,
   parameter int   SEQ_B_IDX = 5,
   parameter int   TRIG_IDX  = 7,
   parameter logic RESET_RD  = 1'b0,
   parameter bit   OUT_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_ctrl,
   input  logic [CODE_W-1:0] in_byte,
   input  logic              in_legal,
   input  logic [1:0]        in_fit,
   input  logic              in_rd_end,
   output logic              out_valid,
   output logic              out_viol,
   output logic              out_spec,
   output logic [CODE_W-1:0] out_code,
   output logic              out_rd
);

   localparam int IDX_W = (N_SPECIAL > 1) ? $clog2(N_SPECIAL) : 1;

   if (CODE_W != 8) begin : g_bad_width
      $error("CODE_W must be 8 to hold the reserved codes");
   end
   if (N_SPECIAL < 1 || N_SPECIAL > 32) begin : g_bad_nspec
      $error("N_SPECIAL out of range");
   end
   if (COMMA_IDX >= N_SPECIAL || SEQ_A_IDX >= N_SPECIAL ||
       SEQ_B_IDX >= N_SPECIAL || TRIG_IDX >= N_SPECIAL) begin : g_bad_idx
      $error("special index parameter outside N_SPECIAL");
   end

   logic              rd_cur;
   logic              prev_vld;
   logic [IDX_W-1:0]  prev_idx;
   rxs_class_e        cls;
   logic              c_viol, c_spec, good_spec;
   logic [CODE_W-1:0] c_code;

   rxs_rd_track #(.RESET_RD(RESET_RD)) u_rd (
      .clk(clk), .rst_n(rst_n), .chr_en(in_valid),
      .rd_next(in_rd_end), .rd_cur(rd_cur)
   );

   rxs_seq_track #(.IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .chr_en(in_valid),
      .good_spec(good_spec), .idx_in(in_byte[IDX_W-1:0]),
      .prev_vld(prev_vld), .prev_idx(prev_idx)
   );

   rxs_classify #(
      .CODE_W(CODE_W), .N_SPECIAL(N_SPECIAL), .IDX_W(IDX_W),
      .COMMA_IDX(COMMA_IDX), .SEQ_A_IDX(SEQ_A_IDX),
      .SEQ_B_IDX(SEQ_B_IDX), .TRIG_IDX(TRIG_IDX)
   ) u_cls (
      .ctrl(in_ctrl), .byte_in(in_byte), .legal(in_legal), .fit(in_fit),
      .rd_cur(rd_cur), .prev_vld(prev_vld), .prev_idx(prev_idx),
      .cls(cls), .viol(c_viol), .spec(c_spec), .code(c_code),
      .good_spec(good_spec)
   );

   assign out_rd = rd_cur;

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_viol  <= 1'b0;
            out_spec  <= 1'b0;
            out_code  <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               out_viol <= c_viol;
               out_spec <= c_spec;
               out_code <= c_code;
            end
         end
      end

      p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == $past(in_valid));
      p_seq_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && (cls == CLS_SEQ_A || cls == CLS_SEQ_B) |-> prev_vld);
      p_unassign_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && !in_legal |=> out_viol && out_code == 8'hE0);
   end else begin : g_out_comb
      always_comb begin
         out_valid = in_valid;
         out_viol  = c_viol;
         out_spec  = c_spec;
         out_code  = c_code;
      end
   end

endmodule

// File: tb/rxs_status_classifier_test.sv
module rxs_status_classifier_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       in_valid, in_ctrl, in_legal, in_rd_end;
   logic [7:0] in_byte;
   logic [1:0] in_fit;
   logic       out_valid, out_viol, out_spec, out_rd;
   logic [7:0] out_code;

   int checks = 0;
   int fails  = 0;

   // model state
   bit       m_rd;
   bit       m_pv;
   int       m_pi;

   always #2.5 clk = ~clk;

   rxs_status_classifier uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctrl(in_ctrl),
      .in_byte(in_byte), .in_legal(in_legal), .in_fit(in_fit),
      .in_rd_end(in_rd_end), .out_valid(out_valid), .out_viol(out_viol),
      .out_spec(out_spec), .out_code(out_code), .out_rd(out_rd)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Returns {viol, spec, code, good_special}
   function automatic logic [10:0] model(input bit c, input int b, input bit lg,
                                         input bit [1:0] f);
      bit fitnow;
      fitnow = m_rd ? f[1] : f[0];
      if (!lg || f == 2'b00 || (c && b > 11)) return {2'b11, 8'hE0, 1'b0};
      if (c && b == 5 && !fitnow) return {2'b11, (m_rd ? 8'hE1 : 8'hE2), 1'b0};
      if (!fitnow) return {2'b11, 8'hE4, 1'b0};
      if (c && b == 7 && m_pv && m_pi == 1) return {2'b11, 8'h27, 1'b0};
      if (c && b == 7 && m_pv && m_pi == 5) return {2'b11, 8'h47, 1'b0};
      if (c) return {2'b01, b[7:0], 1'b1};
      return {2'b00, b[7:0], 1'b0};
   endfunction

   task automatic send(input string req, input bit c, input int b, input bit lg,
                       input bit [1:0] f, input bit re);
      logic [10:0] e;
      @(negedge clk);
      in_valid = 1'b1; in_ctrl = c; in_byte = b[7:0];
      in_legal = lg; in_fit = f; in_rd_end = re;
      e = model(c, b, lg, f);
      @(posedge clk);
      #1;
      check(req, {31'd0, out_valid}, 32'd1);
      check(req, {21'd0, out_viol, out_spec, out_code}, {21'd0, e[10:1]});
      check("R8", {31'd0, out_rd}, {31'd0, re});
      m_rd = re;
      m_pv = e[0];
      m_pi = e[0] ? b : 0;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      #900000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_ctrl = 1'b0; in_byte = 8'h00;
      in_legal = 1'b1; in_fit = 2'b11; in_rd_end = 1'b0;
      m_rd = 1'b0; m_pv = 1'b0; m_pi = 0;
      repeat (3) @(posedge clk);
      #1;
      check("R1", {30'd0, out_valid, out_rd}, 32'd0);
      @(negedge clk); rst_n = 1'b1;
      // R1: no remembered special: K28.7 first passes as C7.0
      send("R1", 1'b1, 7, 1'b1, 2'b11, 1'b0);

      // R11: idle cycles keep state and drop valid
      send("R3", 1'b1, 1, 1'b1, 2'b11, 1'b1);
      repeat (3) begin
         @(posedge clk); #1;
         check("R11", {31'd0, out_valid}, 32'd0);
         check("R11", {31'd0, out_rd}, 32'd1);
      end
      send("R4", 1'b1, 7, 1'b1, 2'b11, 1'b1);   // K28.1 gap K28.7 -> C7.1
      send("R4", 1'b1, 5, 1'b1, 2'b10, 1'b0);   // good K28.5 (pos form, rd +)
      send("R4", 1'b1, 7, 1'b1, 2'b11, 1'b0);   // -> C7.2
      send("R9", 1'b1, 7, 1'b1, 2'b11, 1'b0);   // after K28.7: plain C7.0
      send("R9", 1'b1, 1, 1'b1, 2'b11, 1'b0);
      send("R9", 1'b0, 8'h3C, 1'b1, 2'b11, 1'b0);
      send("R9", 1'b1, 7, 1'b1, 2'b11, 1'b0);   // data cleared memory
      // R6 both comma polarities, and R10 disparity vs sequence
      send("R6", 1'b1, 5, 1'b1, 2'b01, 1'b1);   // rd - : good neg form
      send("R6", 1'b1, 5, 1'b1, 2'b01, 1'b0);   // rd + : C1.7
      send("R6", 1'b1, 5, 1'b1, 2'b10, 1'b1);   // rd - : C2.7
      send("R9", 1'b1, 7, 1'b1, 2'b11, 1'b1);   // after errored comma: C7.0
      send("R3", 1'b1, 1, 1'b1, 2'b11, 1'b0);
      send("R10", 1'b1, 7, 1'b1, 2'b10, 1'b0);  // wrong rd beats sequence: C4.7
      send("R10", 1'b1, 5, 1'b0, 2'b10, 1'b0);  // unassigned beats comma

      // Sweeps: data bytes (R2, R5, R7) and special indices (R3, R5, R7)
      for (int b = 0; b < 256; b++)
         for (int f = 0; f < 4; f++)
            for (int lg = 0; lg < 2; lg++)
               send("R2", 1'b0, b, lg[0], f[1:0], b[0] ^ f[0] ^ lg[0]);
      for (int b = 0; b < 16; b++)
         for (int f = 0; f < 4; f++)
            for (int lg = 0; lg < 2; lg++)
               send("R3", 1'b1, b, lg[0], f[1:0], f[1] ^ lg[0]);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule